// File: doc/BRIEF.md
# Vector Pack With Saturation

This unit takes two 128-bit source vectors, A and B, and narrows each element to half its width. The narrowed elements of A fill the upper half of one 128-bit result, and the narrowed elements of B fill the lower half. Two families of operation are supported.

- **Narrowing packs.** These take halfwords to bytes, or words to halfwords. Each uses one of four flavours: plain truncation, signed clamping, signed-to-unsigned clamping, or unsigned clamping.
- **Pixel pack.** This folds 32-bit pixels into 16-bit 1:5:5:5 pixels.

An 11-bit secondary opcode selects the operation. The result is registered one cycle after the request. Each result comes with a flag that is set when any element was clamped. A sticky saturation bit collects these flags until it is cleared.

Top module: `vpack_sat`

## Requirements
- R1: Elements are numbered big-endian, so element 0 sits in the most significant bits. Result elements 0..N/2-1 are A's elements 0..N/2-1 in order, and result elements N/2..N-1 are B's elements 0..N/2-1 in order.
- R2: Modulo modes keep the low half of each source element and never raise the saturation flag. Opcode 14 packs halfwords to bytes and opcode 78 packs words to halfwords.
- R3: Signed saturate modes clamp a signed source to the signed narrow range. Opcode 398 packs halfwords to bytes with range -128..127 (0x80..0x7F). Opcode 462 packs words to halfwords with range -32768..32767 (0x8000..0x7FFF).
- R4: Signed-to-unsigned modes clamp a negative source to 0 and a source above the unsigned maximum to that maximum (0xFF or 0xFFFF). Opcode 270 works on halfwords and opcode 334 on words.
- R5: Unsigned saturate modes treat the source as an unsigned magnitude and clamp any value above the unsigned narrow maximum to that maximum. For example, 0x8000 becomes 0xFF. Opcode 142 works on halfwords and opcode 206 on words.
- R6: Pixel pack (opcode 782) maps each source word w to the 16-bit value {w[24:19], w[15:11], w[7:3]}. It never raises the saturation flag.
- R7: An accepted request appears on `out_valid`, `out_res` and `out_sat` exactly one clock later. `out_sat` is the OR of the clamp events of all elements of that operation.
- R8: `sat_sticky` is set by any flagged operation and holds until `sat_clr`. If a clear and a flagged operation fall in the same cycle, the bit stays set.
- R9: A request with any other opcode value is dropped. It produces no `out_valid`, leaves `out_res` unchanged and leaves `sat_sticky` untouched.
- R10: Reset (active-low) clears `out_valid`, `out_res`, `out_sat` and `sat_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_xo | input | 11 | Secondary opcode selecting the pack variant |
| in_a | input | 128 | Source vector A (upper result half) |
| in_b | input | 128 | Source vector B (lower result half) |
| sat_clr | input | 1 | Clears the sticky saturation bit |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_res | output | 128 | Packed result |
| out_sat | output | 1 | Clamp event of the current result |
| sat_sticky | output | 1 | Sticky saturation status |

## Verification
The bench aims at range edges: 0x7F/0x80, 0xFF7F/0xFF80, 0x00FF/0x0100 and 0x8000. Here an off-by-one limit compare returns an unclamped byte, and the unsigned flavour, if it were treated as signed, would output 0 instead of 0xFF. Distinct element values in A and B expose a swapped half or reversed element order. Pixel words with every field set separately expose a shifted bit window. Directed cycles cover illegal opcodes, a dropped valid, and a clear coinciding with a flagged operation; a design that loses the event or keeps stale status shows a wrong sticky bit there.

// File: rtl/vpack_sat.sv
module vpack_sat #(
  parameter int VEC_W = 128,
  parameter int XO_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [XO_W-1:0]  in_xo,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_res,
  output logic             out_sat,
  output logic             sat_sticky
);
  localparam int NH = VEC_W / 16;
  localparam int NW = VEC_W / 32;
  localparam int SW = 2 * VEC_W;

  typedef enum logic [3:0] {
    M_NONE, M_HMOD, M_WMOD, M_HUU, M_WUU, M_HSU, M_WSU, M_HSS, M_WSS, M_PIX
  } mode_t;

  mode_t mode;
  always_comb begin
    case (in_xo)
      XO_W'(14):  mode = M_HMOD;
      XO_W'(78):  mode = M_WMOD;
      XO_W'(142): mode = M_HUU;
      XO_W'(206): mode = M_WUU;
      XO_W'(270): mode = M_HSU;
      XO_W'(334): mode = M_WSU;
      XO_W'(398): mode = M_HSS;
      XO_W'(462): mode = M_WSS;
      XO_W'(782): mode = M_PIX;
      default:    mode = M_NONE;
    endcase
  end

  logic [SW-1:0] src;
  assign src = {in_a, in_b};

  logic [VEC_W-1:0] pk_h, pk_w, pk_px;
  logic [2*NH-1:0]  clip_h;
  logic [2*NW-1:0]  clip_w;

  always_comb begin
    pk_h   = '0;
    clip_h = '0;
    for (int i = 0; i < 2*NH; i++) begin
      logic [15:0] e;
      logic [7:0]  o;
      logic        c;
      e = src[SW-1-16*i -: 16];
      o = e[7:0];
      c = 1'b0;
      case (mode)
        M_HSS: begin
          if (!e[15] && e[14:7] != 8'h00) begin o = 8'h7F; c = 1'b1; end
          else if (e[15] && e[14:7] != 8'hFF) begin o = 8'h80; c = 1'b1; end
        end
        M_HSU: begin
          if (e[15]) begin o = 8'h00; c = 1'b1; end
          else if (e[14:8] != 7'h00) begin o = 8'hFF; c = 1'b1; end
        end
        M_HUU: begin
          if (e[15:8] != 8'h00) begin o = 8'hFF; c = 1'b1; end
        end
        default: ;
      endcase
      pk_h[VEC_W-1-8*i -: 8] = o;
      clip_h[i] = c;
    end
  end

  always_comb begin
    pk_w   = '0;
    clip_w = '0;
    for (int i = 0; i < 2*NW; i++) begin
      logic [31:0] e;
      logic [15:0] o;
      logic        c;
      e = src[SW-1-32*i -: 32];
      o = e[15:0];
      c = 1'b0;
      case (mode)
        M_WSS: begin
          if (!e[31] && e[30:15] != 16'h0000) begin o = 16'h7FFF; c = 1'b1; end
          else if (e[31] && e[30:15] != 16'hFFFF) begin o = 16'h8000; c = 1'b1; end
        end
        M_WSU: begin
          if (e[31]) begin o = 16'h0000; c = 1'b1; end
          else if (e[30:16] != 15'h0000) begin o = 16'hFFFF; c = 1'b1; end
        end
        M_WUU: begin
          if (e[31:16] != 16'h0000) begin o = 16'hFFFF; c = 1'b1; end
        end
        default: ;
      endcase
      pk_w[VEC_W-1-16*i -: 16] = o;
      clip_w[i] = c;
    end
  end

  always_comb begin
    pk_px = '0;
    for (int i = 0; i < 2*NW; i++) begin
      logic [31:0] w;
      w = src[SW-1-32*i -: 32];
      pk_px[VEC_W-1-16*i -: 16] = {w[24:19], w[15:11], w[7:3]};
    end
  end

  logic is_h, is_w, go, sat_nx;
  logic [VEC_W-1:0] res_nx;
  assign is_h   = mode inside {M_HMOD, M_HUU, M_HSU, M_HSS};
  assign is_w   = mode inside {M_WMOD, M_WUU, M_WSU, M_WSS};
  assign go     = in_valid && (mode != M_NONE);
  assign res_nx = is_h ? pk_h : (is_w ? pk_w : pk_px);
  assign sat_nx = is_h ? |clip_h : (is_w ? |clip_w : 1'b0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_res    <= '0;
      out_sat    <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid  <= go;
      out_sat    <= go && sat_nx;
      if (go) out_res <= res_nx;
      sat_sticky <= (sat_sticky && !sat_clr) || (go && sat_nx);
    end
  end
endmodule

// File: rtl/vpack_sat_chk.sv
module vpack_sat_chk #(
  parameter int VEC_W = 128,
  parameter int XO_W  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [XO_W-1:0]  in_xo,
  input logic             sat_clr,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_res,
  input logic             out_sat,
  input logic             sat_sticky
);
  // R7
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R7
  sat_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat |-> out_valid);
  // R8
  sticky_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat |-> sat_sticky);
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sat_clr) |=> sat_sticky);
  // R8
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_sticky) |-> out_sat);
  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_res));
  // R2
  mod_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_xo == XO_W'(14) || in_xo == XO_W'(78))) |=> !out_sat);
  // R6
  pix_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_xo == XO_W'(782)) |=> !out_sat);
endmodule

bind vpack_sat vpack_sat_chk #(.VEC_W(VEC_W), .XO_W(XO_W)) u_chk (.*);

// File: tb/tb_vpack_sat.sv
module tb_vpack_sat;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [10:0]  in_xo = '0;
  logic [127:0] in_a = '0, in_b = '0;
  logic         sat_clr = 1'b0;
  logic         out_valid, out_sat, sat_sticky;
  logic [127:0] out_res;

  vpack_sat dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit checking = 1'b0;

  logic [127:0] e_res = '0;
  bit e_valid = 0, e_sat = 0, e_sticky = 0;
  string e_tag = "R10";

  task automatic model(input logic [10:0] xo, input logic [127:0] a, b,
                       output logic [127:0] r, output bit s, output bit ok,
                       output string tag);
    int n, kind;
    ok = 1; r = '0; s = 0; n = 8; kind = 0;
    case (xo)
      11'd14:  begin n = 8;  kind = 0; end
      11'd78:  begin n = 16; kind = 0; end
      11'd398: begin n = 8;  kind = 1; end
      11'd462: begin n = 16; kind = 1; end
      11'd270: begin n = 8;  kind = 2; end
      11'd334: begin n = 16; kind = 2; end
      11'd142: begin n = 8;  kind = 3; end
      11'd206: begin n = 16; kind = 3; end
      11'd782: begin n = 16; kind = 4; end
      default: ok = 0;
    endcase
    case (kind)
      0: tag = "R1/R2";
      1: tag = "R1/R3";
      2: tag = "R1/R4";
      3: tag = "R1/R5";
      default: tag = "R1/R6";
    endcase
    if (!ok) return;
    if (kind == 4) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] w;
        logic [127:0] p;
        w = 32'((k < 4 ? a : b) >> (96 - 32*(k % 4)));
        p = 128'(((w >> 19) & 63) << 10 | ((w >> 11) & 31) << 5 | ((w >> 3) & 31));
        r |= p << (112 - 16*k);
      end
    end else begin
      int sw, per;
      longint umax, smax, smin;
      sw = 2*n; per = 128/sw;
      umax = (64'sd1 << n) - 1; smax = (64'sd1 << (n-1)) - 1; smin = -(64'sd1 << (n-1));
      for (int k = 0; k < 2*per; k++) begin
        longint u, sv, o;
        logic [127:0] src, p;
        src = (k < per) ? a : b;
        u = longint'((src >> (128 - sw*((k % per) + 1))) & ((128'd1 << sw) - 1));
        sv = (u >= (64'sd1 << (sw-1))) ? u - (64'sd1 << sw) : u;
        o = u;
        case (kind)
          1: begin o = sv; if (sv > smax) begin o = smax; s = 1; end
                   else if (sv < smin) begin o = smin; s = 1; end end
          2: begin o = sv; if (sv < 0) begin o = 0; s = 1; end
                   else if (sv > umax) begin o = umax; s = 1; end end
          3: if (u > umax) begin o = umax; s = 1; end
          default: ;
        endcase
        p = 128'(o & umax);
        r |= p << (128 - n*(k+1));
      end
    end
  endtask

  always @(posedge clk) begin
    logic [127:0] r; bit s, ok; string t;
    if (!rst_n) begin
      e_valid = 0; e_sat = 0; e_sticky = 0; e_res = '0; e_tag = "R10";
    end else begin
      model(in_xo, in_a, in_b, r, s, ok, t);
      e_valid = in_valid && ok;
      e_sat = e_valid && s;
      if (e_valid) begin e_res = r; e_tag = t; end
      else e_tag = "R9";
      e_sticky = (e_sticky && !sat_clr) || e_sat;
    end
  end

  always @(negedge clk) if (checking) begin
    vectors++;
    if (out_valid !== e_valid) begin
      miscompares++;
      $display("FAIL %s/R7 out_valid actual=%0b expected=%0b", e_tag, out_valid, e_valid);
    end
    if (out_sat !== e_sat) begin
      miscompares++;
      $display("FAIL %s/R7 out_sat actual=%0b expected=%0b", e_tag, out_sat, e_sat);
    end
    if (sat_sticky !== e_sticky) begin
      miscompares++;
      $display("FAIL R8 sat_sticky actual=%0b expected=%0b", sat_sticky, e_sticky);
    end
    if (out_res !== e_res) begin
      miscompares++;
      $display("FAIL %s out_res actual=%h expected=%h", e_tag, out_res, e_res);
    end
  end

  task automatic op(input logic [10:0] xo, input logic [127:0] a, b,
                    input bit v = 1, input bit clr = 0);
    @(negedge clk);
    in_valid = v; in_xo = xo; in_a = a; in_b = b; sat_clr = clr;
  endtask

  task automatic idle(input bit clr = 0);
    @(negedge clk);
    in_valid = 0; sat_clr = clr;
  endtask

  initial begin
    #(CLK_NS * 200000);
    miscompares++;
    $display("FAIL R7 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  localparam logic [10:0] OPS [9] = '{11'd14, 11'd78, 11'd142, 11'd206, 11'd270,
                                      11'd334, 11'd398, 11'd462, 11'd782};

  initial begin
    checking = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R2: ordering and truncation
    op(11'd14, 128'h1011_1213_1415_1617_1819_1A1B_1C1D_1E1F,
               128'h2021_2223_2425_2627_2829_2A2B_2C2D_2E2F);
    op(11'd78, 128'h0001_1111_0002_2222_FFFF_3333_8000_4444,
               128'hAAAA_5555_BBBB_6666_CCCC_7777_DDDD_8888);
    // R3: signed halfword edges, then signed word edges
    op(11'd398, 128'h007F_0080_FF80_FF7F_8000_7FFF_0000_FFFF,
                128'h0001_0100_FE00_0040_FFC0_007E_FF81_0000);
    idle(1);
    op(11'd462, 128'h00007FFF_00008000_FFFF8000_FFFF7FFF,
                128'h80000000_7FFFFFFF_00000001_FFFFFFFF);
    idle(1);
    // R4: signed to unsigned
    op(11'd270, 128'h00FF_0100_FFFF_8000_0000_0001_7FFF_0080,
                128'h0011_0022_0033_0044_0055_0066_0077_0088);
    idle(1);
    op(11'd334, 128'h0000FFFF_00010000_FFFFFFFF_80000000,
                128'h00001234_00005678_00009ABC_0000DEF0);
    // R5: unsigned saturate incl. 0x8000 magnitude
    idle(1);
    op(11'd142, 128'h8000_00FF_0100_FFFF_0000_0080_0001_00FE,
                128'h0012_0034_0056_0078_009A_00BC_00DE_00F0);
    idle(1);
    op(11'd206, 128'h80000000_0000FFFF_00010000_00000000,
                128'h0000AAAA_0000BBBB_FFFFFFFF_00008000);
    // R6: pixel fields individually
    op(11'd782, 128'h01F80000_0000F800_000000F8_FFFFFFFF,
                128'h00080808_00100000_12345678_00000007);
    // R9: illegal opcode and dropped valid
    op(11'd15, '1, '1);
    op(11'd398, 128'h7FFF_7FFF_7FFF_7FFF_7FFF_7FFF_7FFF_7FFF, '0, 0);
    op(11'd0, '1, '1);
    // R8: clear in same cycle as a flagged op, then clear alone
    op(11'd398, 128'h7FFF_0000_0000_0000_0000_0000_0000_0000, '0, 1, 1);
    idle(0);
    idle(1);
    idle(0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [10:0] xo;
      xo = ($urandom_range(0, 9) == 9) ? 11'($urandom) : OPS[$urandom_range(0, 8)];
      op(xo, {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom},
         $urandom_range(0, 7) != 0, $urandom_range(0, 15) == 0);
    end
    // R10: reset again mid-stream
    op(11'd398, '1, 128'h7FFF0000, 1, 0);
    @(negedge clk); rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule